// File: doc/BRIEF.md
# Issue-to-Execute Slot Register

This block sits between instruction issue and execution and holds a small set of in-flight instruction records. Each record occupies one slot and carries an opaque payload together with a 32-bit unique id that producers hand out in increasing order. A producer writes a record into a free slot; a consumer always sees, and may remove, the record with the smallest unique id, so the oldest instruction leaves first regardless of which slot it sits in.

Two placement modes are offered. In shared mode a write takes the lowest-numbered empty slot. In partitioned mode each scheduler owns the slot whose index equals its scheduler number, may write only there, and the free indication looks only at that slot. A write that finds no acceptable slot is dropped, and an error pulse follows one cycle later.

Top module: `issue_slot_reg`

## Requirements
- R1: `has_free` is 1 in shared mode when at least one slot is empty; `has_ready` is 1 when at least one slot holds a record.
- R2: In shared mode (`part_mode`=0) an accepted write lands in the empty slot with the lowest index, observable on `head_slot` once that record is the oldest.
- R3: In partitioned mode (`part_mode`=1) an accepted write lands in slot `wr_sched`, and `has_free` equals 1 exactly when slot `wr_sched` is empty, whatever the other slots hold.
- R4: `head_uid`, `head_payload` and `head_slot` present the occupied slot whose unique id is smallest, compared as unsigned numbers.
- R5: A drain (`rd_en`=1 while `has_ready`=1) empties the slot shown on `head_slot` at the next clock edge.
- R6: A write issued while `has_free`=0 leaves every slot unchanged, and `wr_err` is 1 for exactly the one cycle after that edge.
- R7: When a drain and a write share a cycle, both take effect, but the write is judged against the slot state before the drain, so the slot being freed cannot be reused until the following cycle.
- R8: After reset all slots are empty: `has_ready`=0, `has_free`=1, `wr_err`=0, `head_uid`=0.
- R9: A drain requested while no record is held changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| part_mode | input | 1 | 1 selects per-scheduler slot ownership |
| wr_en | input | 1 | Write request |
| wr_sched | input | $clog2(SLOTS) | Scheduler number of the writer |
| wr_uid | input | UID_W | Unique id of the record |
| wr_payload | input | PAYLOAD_W | Opaque instruction data |
| rd_en | input | 1 | Drain request for the oldest record |
| has_free | output | 1 | A write would be accepted this cycle |
| has_ready | output | 1 | At least one record is held |
| head_uid | output | UID_W | Unique id of the oldest record |
| head_payload | output | PAYLOAD_W | Payload of the oldest record |
| head_slot | output | $clog2(SLOTS) | Slot index of the oldest record |
| wr_err | output | 1 | Pulse one cycle after a rejected write |

## Verification
A drain and a write can land on the same edge, and the interesting case is a full register where the drain frees a slot the write might try to grab. The bench provokes this by filling every slot and then raising both requests together; it expects the write to be rejected with an error pulse, the oldest record to leave, and a write on the next cycle to take the freed slot. A scoreboard queue holds the expected oldest record for every drain and compares it against the head outputs at the moment the drain is requested.

// File: rtl/issue_slot_reg.sv
module issue_slot_reg #(
  parameter int SLOTS     = 4,
  parameter int UID_W     = 32,
  parameter int PAYLOAD_W = 16,
  localparam int IDX_W    = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 part_mode,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_sched,
  input  logic [UID_W-1:0]     wr_uid,
  input  logic [PAYLOAD_W-1:0] wr_payload,
  input  logic                 rd_en,
  output logic                 has_free,
  output logic                 has_ready,
  output logic [UID_W-1:0]     head_uid,
  output logic [PAYLOAD_W-1:0] head_payload,
  output logic [IDX_W-1:0]     head_slot,
  output logic                 wr_err
);

  logic [SLOTS-1:0]     occ;
  logic [UID_W-1:0]     uid_q [SLOTS];
  logic [PAYLOAD_W-1:0] pay_q [SLOTS];

  logic [IDX_W-1:0] first_empty;
  logic [IDX_W-1:0] target;
  logic             accept_wr;
  logic             accept_rd;

  always_comb begin
    first_empty = '0;
    for (int i = SLOTS - 1; i >= 0; i--)
      if (!occ[i]) first_empty = IDX_W'(i);
  end

  always_comb begin
    head_slot    = '0;
    head_uid     = '0;
    head_payload = '0;
    has_ready    = 1'b0;
    for (int i = 0; i < SLOTS; i++) begin
      if (occ[i] && (!has_ready || uid_q[i] < head_uid)) begin
        has_ready    = 1'b1;
        head_slot    = IDX_W'(i);
        head_uid     = uid_q[i];
        head_payload = pay_q[i];
      end
    end
  end

  assign has_free  = part_mode ? !occ[wr_sched] : !(&occ);
  assign target    = part_mode ? wr_sched : first_empty;
  assign accept_wr = wr_en && has_free;
  assign accept_rd = rd_en && has_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ    <= '0;
      wr_err <= 1'b0;
      for (int i = 0; i < SLOTS; i++) begin
        uid_q[i] <= '0;
        pay_q[i] <= '0;
      end
    end else begin
      wr_err <= wr_en && !has_free;
      if (accept_rd) occ[head_slot] <= 1'b0;
      if (accept_wr) begin
        occ[target]   <= 1'b1;
        uid_q[target] <= wr_uid;
        pay_q[target] <= wr_payload;
      end
    end
  end

endmodule

// File: rtl/issue_slot_reg_chk.sv
module issue_slot_reg_chk #(
  parameter int UID_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             part_mode,
  input logic             wr_en,
  input logic             rd_en,
  input logic             has_free,
  input logic             has_ready,
  input logic             wr_err,
  input logic [UID_W-1:0] head_uid
);

  AST_EMPTY_MEANS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !has_ready |-> has_free); // R1

  AST_PART_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    part_mode && wr_en && has_free |=> has_ready); // R3

  AST_REJECT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !has_free |=> wr_err); // R6

  AST_REJECT_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !has_free && !rd_en |=> $stable(head_uid) && has_ready == $past(has_ready)); // R6

  AST_DRAIN_ADVANCES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && has_ready && !wr_en |=> !has_ready || head_uid != $past(head_uid)); // R5

  AST_IDLE_DRAIN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && !has_ready && !wr_en |=> !has_ready); // R9

  AST_ERR_ONLY_AFTER_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !has_free) |=> !wr_err); // R6

endmodule

bind issue_slot_reg issue_slot_reg_chk #(.UID_W(UID_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .part_mode(part_mode), .wr_en(wr_en), .rd_en(rd_en),
  .has_free(has_free), .has_ready(has_ready), .wr_err(wr_err), .head_uid(head_uid)
);

// File: tb/issue_slot_reg_test.sv
module issue_slot_reg_test;
  localparam int PERIOD = 10;
  localparam int SLOTS  = 4;
  localparam int IDX_W  = 2;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        part_mode = 0, wr_en = 0, rd_en = 0;
  logic [1:0]  wr_sched = 0;
  logic [31:0] wr_uid = 0;
  logic [15:0] wr_payload = 0;
  logic        has_free, has_ready, wr_err;
  logic [31:0] head_uid;
  logic [15:0] head_payload;
  logic [1:0]  head_slot;

  issue_slot_reg #(.SLOTS(SLOTS), .UID_W(32), .PAYLOAD_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .part_mode(part_mode), .wr_en(wr_en),
    .wr_sched(wr_sched), .wr_uid(wr_uid), .wr_payload(wr_payload), .rd_en(rd_en),
    .has_free(has_free), .has_ready(has_ready), .head_uid(head_uid),
    .head_payload(head_payload), .head_slot(head_slot), .wr_err(wr_err)
  );

  always #(PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0;
  bit m_occ [SLOTS];
  int m_uid [SLOTS];
  int m_pay [SLOTS];
  int q_uid [$];
  int q_pay [$];
  int q_slot [$];
  event mon_ev;
  string cur_tag;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  initial forever begin
    @(mon_ev);
    chk(head_uid == q_uid[0], {cur_tag, " head uid (R4)"}, head_uid, q_uid[0]);
    chk(head_payload == q_pay[0], {cur_tag, " head payload (R4)"}, head_payload, q_pay[0]);
    chk(head_slot == q_slot[0], {cur_tag, " head slot (R2/R3)"}, head_slot, q_slot[0]);
    void'(q_uid.pop_front()); void'(q_pay.pop_front()); void'(q_slot.pop_front());
  end

  task automatic step(input string tag, input bit pm, input bit we, input int sch,
                      input int uid, input bit re);
    bit any, free, exp_err;
    int best, tgt;
    @(negedge clk);
    cur_tag = tag;
    part_mode = pm; wr_en = we; wr_sched = sch[1:0]; wr_uid = uid;
    wr_payload = 16'(uid + 100); rd_en = re;
    #1;
    any = 0; best = -1; tgt = -1;
    for (int i = 0; i < SLOTS; i++) begin
      if (m_occ[i] && (best < 0 || m_uid[i] < m_uid[best])) best = i;
      if (!m_occ[i] && tgt < 0) tgt = i;
    end
    any = (best >= 0);
    if (pm) begin free = !m_occ[sch]; tgt = sch; end else free = (tgt >= 0);
    chk(has_free == free, {tag, " has_free (R1/R3)"}, has_free, free);
    chk(has_ready == any, {tag, " has_ready (R1/R9)"}, has_ready, any);
    if (re && any) begin
      q_uid.push_back(m_uid[best]); q_pay.push_back(m_pay[best] & 16'hFFFF);
      q_slot.push_back(best);
      ->mon_ev;
    end
    exp_err = we && !free;
    @(posedge clk);
    if (re && any) m_occ[best] = 0;
    if (we && free) begin m_occ[tgt] = 1; m_uid[tgt] = uid; m_pay[tgt] = uid + 100; end
    #1;
    chk(wr_err == exp_err, {tag, " wr_err (R6/R7)"}, wr_err, exp_err);
  endtask

  task automatic finish_run;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    #(PERIOD * 20000);
    fails++; tests++;
    $display("FAIL watchdog R8 actual=0 expected=1");
    finish_run();
  end

  initial begin
    for (int i = 0; i < SLOTS; i++) m_occ[i] = 0;
    #(PERIOD * 2 + 2);
    chk(has_ready == 0, "R8 reset ready", has_ready, 0);
    chk(has_free == 1, "R8 reset free", has_free, 1);
    chk(wr_err == 0, "R8 reset err", wr_err, 0);
    chk(head_uid == 0, "R8 reset uid", head_uid, 0);
    rst_n = 1;
    step("R9 drain empty", 0, 0, 0, 0, 1);
    step("R2 wr10", 0, 1, 0, 10, 0);
    step("R2 wr11", 0, 1, 0, 11, 0);
    step("R2 wr12", 0, 1, 0, 12, 0);
    step("R5 drain10", 0, 0, 0, 0, 1);
    step("R2 wr13 reuse", 0, 1, 0, 13, 0);
    step("R4 peek", 0, 0, 0, 0, 1);
    step("R2 wr14", 0, 1, 0, 14, 0);
    step("R1 wr15", 0, 1, 0, 15, 0);
    step("R6 full wr16", 0, 1, 0, 16, 0);
    step("R7 drain+wr17", 0, 1, 0, 17, 1);
    step("R7 wr18 next", 0, 1, 0, 18, 0);
    step("R7 full again", 0, 0, 0, 0, 0);
    for (int k = 0; k < 5; k++) step("R5 drain all", 0, 0, 0, 0, 1);
    step("R9 empty idle", 0, 0, 0, 0, 1);
    step("R3 wr s2", 1, 1, 2, 20, 0);
    step("R3 free s1", 1, 0, 1, 0, 0);
    step("R3 reject s2", 1, 1, 2, 21, 0);
    step("R3 wr s0", 1, 1, 0, 22, 0);
    step("R3 wr s3", 1, 1, 3, 23, 0);
    step("R7 drain+s2", 1, 1, 2, 24, 1);
    step("R3 wr s2 next", 1, 1, 2, 25, 0);
    for (int k = 0; k < 4; k++) step("R5 sub drain", 1, 0, 0, 0, 1);
    step("R9 final", 1, 0, 0, 0, 0);
    chk(q_uid.size() == 0, "R4 scoreboard empty", q_uid.size(), 0);
    finish_run();
  end
endmodule